// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block is the digital control core of a multiphase buck converter. When enable is raised, it spends a short detection window sampling two indicators that report whether the phase-3 and phase-4 outputs are grounded. From those samples it fixes the number of active phases at 4, 3 or 2. The grounded phases are switched off for the whole enabled period.

Once detection ends, the block hands out one set pulse per master-clock cycle to the active phases in turn. Each phase therefore switches at the master frequency divided by the phase count. Every phase has its own flip-flop, which its slot sets and its own reset-request input clears. The phases never block each other, so several outputs can be high together and a phase can stay high for almost its whole period. Lowering enable clears everything, and the next enable runs detection again.

Top module: `mphase_seq`

## Requirements
- R1: While reset is asserted, and after it until enable is raised, `pwm_o` is 0, `det_done_o` is 0 and `ph_cnt_o` is 0.
- R2: The first rising clock edge at which enable is seen high starts detection. The next two edges sample the detect inputs, and `det_done_o` goes high after the second of them. While `det_done_o` is low, every `pwm_o` bit is low.
- R3: With neither detect input seen high during the window, `ph_cnt_o` reads 4, written as a binary phase count.
- R4: With only the phase-4 input seen high, `ph_cnt_o` reads 3.
- R5: With the phase-3 input seen high, `ph_cnt_o` reads 2, whatever the phase-4 input did.
- R6: Detect inputs outside the window have no effect. `ph_cnt_o` and the set of phases that can switch stay fixed until enable drops.
- R7: `pwm_o[0]` is phase 1. On the first edge after `det_done_o` rises, phase 1 gets the set pulse. Each later edge sets the next active phase, and after the last active phase the order wraps to phase 1. At most one output rises per edge.
- R8: A phase outside the active count (bit 3 for a count of 3, bits 3:2 for a count of 2) never goes high.
- R9: An active phase that has been set stays high until an edge at which its own `ph_rst_req` bit is high. Any number of outputs can be high at once.
- R10: If a phase's reset request is high at the same edge as its set pulse, the phase is low after that edge.
- R11: An edge with enable low clears all outputs, `det_done_o` and `ph_cnt_o`. The next enable runs a new detection.
- R12: A detect input that is high in either of the two sampling cycles marks its phase as grounded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; lowering it clears the block |
| sense_ph3_gnd | input | 1 | High when the phase-3 output reads as grounded |
| sense_ph4_gnd | input | 1 | High when the phase-4 output reads as grounded |
| ph_rst_req | input | 4 | Per-phase reset request from the compare logic |
| pwm_o | output | 4 | Logic-level PWM outputs, bit 0 is phase 1 |
| ph_cnt_o | output | 3 | Number of active phases, 0 until detection ends |
| det_done_o | output | 1 | High once detection has ended and switching runs |

## Verification
The case that matters is a phase's set pulse from the slot rotator landing on the same edge as that phase's reset request. The bench forces this collision directly by raising the request bit for exactly the phase whose slot comes up next, and it also meets it by chance under random request traffic. The result is judged by expecting the phase to be low after the edge, while the other phases keep the values they held.

// File: rtl/mphase_pkg.sv
package mphase_pkg;

    localparam int PH_MAX = 4;
    localparam int CNT_W  = $clog2(PH_MAX + 1);
    localparam int SLOT_W = $clog2(PH_MAX);

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_DETECT = 2'd1,
        SQ_RUN    = 2'd2
    } seq_state_e;

    // sticky grounded indications gathered during the window
    typedef struct packed {
        logic ph3_gnd;
        logic ph4_gnd;
    } gnd_flags_t;

    typedef logic [PH_MAX-1:0] ph_vec_t;
    typedef logic [CNT_W-1:0]  ph_cnt_t;

    function automatic ph_cnt_t phases_from_flags(gnd_flags_t f);
        ph_cnt_t n;
        if (f.ph3_gnd)
            n = CNT_W'(2);
        else if (f.ph4_gnd)
            n = CNT_W'(3);
        else
            n = CNT_W'(PH_MAX);
        return n;
    endfunction

    function automatic ph_vec_t mask_from_count(ph_cnt_t n);
        ph_vec_t m;
        for (int i = 0; i < PH_MAX; i++)
            m[i] = (CNT_W'(i) < n);
        return m;
    endfunction

endpackage

// File: rtl/mphase_detect.sv
module mphase_detect
    import mphase_pkg::*;
#(
    parameter int DET_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ph3_gnd_in,
    input  logic       ph4_gnd_in,
    output logic       run,
    output gnd_flags_t flags
);

    localparam int DW = (DET_CYCLES > 1) ? $clog2(DET_CYCLES) : 1;
    localparam logic [DW-1:0] LAST = DW'(DET_CYCLES - 1);

    seq_state_e      st_q;
    logic [DW-1:0]   win_q;
    gnd_flags_t      flg_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q  <= SQ_IDLE;
            win_q <= '0;
            flg_q <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    st_q  <= SQ_DETECT;
                    win_q <= '0;
                    flg_q <= '0;
                end
                SQ_DETECT: begin
                    flg_q.ph3_gnd <= flg_q.ph3_gnd | ph3_gnd_in;
                    flg_q.ph4_gnd <= flg_q.ph4_gnd | ph4_gnd_in;
                    if (win_q == LAST)
                        st_q <= SQ_RUN;
                    else
                        win_q <= win_q + DW'(1);
                end
                SQ_RUN: begin
                    st_q <= SQ_RUN;
                end
                default: begin
                    st_q <= SQ_IDLE;
                end
            endcase
        end
    end

    assign run   = (st_q == SQ_RUN);
    assign flags = flg_q;

endmodule

// File: rtl/mphase_slot.sv
module mphase_slot
    import mphase_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  ph_cnt_t ph_cnt,
    input  ph_vec_t act_mask,
    output ph_vec_t set_vec
);

    logic [SLOT_W-1:0] slot_q;
    ph_cnt_t           last_full;
    logic [SLOT_W-1:0] last_slot;

    assign last_full = ph_cnt - CNT_W'(1);
    assign last_slot = last_full[SLOT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || !run)
            slot_q <= '0;
        else if (slot_q == last_slot)
            slot_q <= '0;
        else
            slot_q <= slot_q + SLOT_W'(1);
    end

    for (genvar g = 0; g < PH_MAX; g++) begin : g_set
        assign set_vec[g] = run && act_mask[g] && (slot_q == SLOT_W'(g));
    end

endmodule

// File: rtl/mphase_cell.sv
module mphase_cell (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic active,
    input  logic set_p,
    input  logic rst_req,
    output logic pwm
);

    logic q;

    always_ff @(posedge clk) begin
        if (rst || clr || !active)
            q <= 1'b0;
        else if (rst_req)
            q <= 1'b0;
        else if (set_p)
            q <= 1'b1;
    end

    assign pwm = q;

endmodule

// File: rtl/mphase_seq.sv
module mphase_seq
    import mphase_pkg::*;
#(
    parameter int DET_CYCLES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   sense_ph3_gnd,
    input  logic                   sense_ph4_gnd,
    input  logic [PH_MAX-1:0]      ph_rst_req,
    output logic [PH_MAX-1:0]      pwm_o,
    output logic [CNT_W-1:0]       ph_cnt_o,
    output logic                   det_done_o
);

    logic       run;
    gnd_flags_t flags;
    ph_cnt_t    ph_cnt;
    ph_vec_t    act_mask;
    ph_vec_t    set_vec;

    mphase_detect #(.DET_CYCLES(DET_CYCLES)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .ph3_gnd_in (sense_ph3_gnd),
        .ph4_gnd_in (sense_ph4_gnd),
        .run        (run),
        .flags      (flags)
    );

    assign ph_cnt   = run ? phases_from_flags(flags) : '0;
    assign act_mask = mask_from_count(ph_cnt);

    mphase_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .ph_cnt   (ph_cnt),
        .act_mask (act_mask),
        .set_vec  (set_vec)
    );

    for (genvar g = 0; g < PH_MAX; g++) begin : g_cell
        mphase_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .clr     (!en || !run),
            .active  (act_mask[g]),
            .set_p   (set_vec[g]),
            .rst_req (ph_rst_req[g]),
            .pwm     (pwm_o[g])
        );
    end

    assign ph_cnt_o   = ph_cnt;
    assign det_done_o = run;

endmodule

// File: rtl/mphase_seq_chk.sv
module mphase_seq_chk
    import mphase_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic [PH_MAX-1:0]   ph_rst_req,
    input logic [PH_MAX-1:0]   pwm_o,
    input logic [CNT_W-1:0]    ph_cnt_o,
    input logic                det_done_o
);

    p_quiet_detect_r2: assert property (@(posedge clk) disable iff (rst)
        !det_done_o |-> (pwm_o == '0));

    p_cnt_legal_r3: assert property (@(posedge clk) disable iff (rst)
        det_done_o |-> (ph_cnt_o == CNT_W'(2) || ph_cnt_o == CNT_W'(3) || ph_cnt_o == CNT_W'(4)));

    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (det_done_o && $past(det_done_o)) |-> $stable(ph_cnt_o));

    p_one_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pwm_o & ~$past(pwm_o)));

    p_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (ph_cnt_o == CNT_W'(3) |-> !pwm_o[3]) and (ph_cnt_o == CNT_W'(2) |-> (pwm_o[3:2] == 2'b00)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $past(en && det_done_o) |-> ((($past(pwm_o) & ~$past(ph_rst_req)) & ~pwm_o) == '0));

    p_req_wins_r10: assert property (@(posedge clk) disable iff (rst)
        $past(en && det_done_o) |-> ((pwm_o & $past(ph_rst_req)) == '0));

    p_disable_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $past(!en) |-> (pwm_o == '0 && !det_done_o && ph_cnt_o == '0));

endmodule

bind mphase_seq mphase_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .ph_rst_req (ph_rst_req),
    .pwm_o      (pwm_o),
    .ph_cnt_o   (ph_cnt_o),
    .det_done_o (det_done_o)
);

// File: tb/mphase_seq_test.sv
module mphase_seq_test;

    logic       clk = 1'b0;
    logic       rst, en, g3, g4;
    logic [3:0] rq;
    logic [3:0] pwm;
    logic [2:0] cnt;
    logic       done;

    always #2 clk = ~clk;

    mphase_seq uut (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .sense_ph3_gnd (g3),
        .sense_ph4_gnd (g4),
        .ph_rst_req    (rq),
        .pwm_o         (pwm),
        .ph_cnt_o      (cnt),
        .det_done_o    (done)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string tag = "R1";

    // reference state: 0 idle, 1 detect, 2 run
    int         m_st = 0;
    int         m_k = 0;
    bit         m_g3 = 0, m_g4 = 0;
    int         m_slot = 0;
    logic [3:0] m_pwm = '0;

    function automatic int exp_n(bit a3, bit a4);
        if (a3) return 2;
        if (a4) return 3;
        return 4;
    endfunction

    function automatic logic [3:0] exp_mask(int n);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = (i < n);
        return m;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int n;
        logic [3:0] nx;
        if (rst || !en) begin
            m_st = 0; m_k = 0; m_g3 = 0; m_g4 = 0; m_slot = 0; m_pwm = '0;
        end else if (m_st == 0) begin
            m_st = 1; m_k = 0; m_g3 = 0; m_g4 = 0; m_pwm = '0;
        end else if (m_st == 1) begin
            m_g3 = m_g3 | g3;
            m_g4 = m_g4 | g4;
            if (m_k == 1) begin m_st = 2; m_slot = 0; end
            else m_k++;
        end else begin
            n  = exp_n(m_g3, m_g4);
            nx = m_pwm;
            for (int i = 0; i < 4; i++) begin
                if (!exp_mask(n)[i] || rq[i]) nx[i] = 1'b0;
                else if (m_slot == i) nx[i] = 1'b1;
            end
            m_pwm  = nx;
            m_slot = (m_slot == n - 1) ? 0 : m_slot + 1;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        check(tag, "pwm", int'(pwm), int'(m_pwm));
        check(tag, "done", int'(done), (m_st == 2) ? 1 : 0);
        check(tag, "cnt", int'(cnt), (m_st == 2) ? exp_n(m_g3, m_g4) : 0);
    endtask

    task automatic enable_with(bit s3a, bit s4a, bit s3b, bit s4b);
        en = 1; g3 = 0; g4 = 0;
        cyc();
        g3 = s3a; g4 = s4a;
        cyc();
        check("R2", "done mid-window", int'(done), 0);
        g3 = s3b; g4 = s4b;
        cyc();
        check("R2", "done end-window", int'(done), 1);
        g3 = 0; g4 = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        rst = 1; en = 0; g3 = 0; g4 = 0; rq = '0;
        tag = "R1";
        repeat (3) cyc();
        rst = 0;
        repeat (2) cyc();
        check("R1", "pwm idle", int'(pwm), 0);

        // four phases, free running with no resets
        tag = "R2";
        enable_with(0, 0, 0, 0);
        check("R3", "cnt four", int'(cnt), 4);
        tag = "R7";
        cyc();
        check("R7", "phase1 first", int'(pwm), 1);
        cyc();
        check("R7", "phase2 next", int'(pwm), 3);
        repeat (3) cyc();
        check("R9", "all high", int'(pwm), 15);

        tag = "R9";
        for (int c = 0; c < 24; c++) begin
            rq = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            cyc();
        end
        rq = '0;

        // reset request aimed at the slot being set
        tag = "R10";
        for (int c = 0; c < 8; c++) begin
            int s;
            s = m_slot;
            rq = 4'(1 << s);
            cyc();
            check("R10", "collide", int'(pwm[s]), 0);
        end
        rq = '0;

        tag = "R11";
        en = 0;
        cyc();
        check("R11", "cleared", int'(pwm), 0);
        check("R11", "done low", int'(done), 0);

        // phase 4 grounded in first sample only
        tag = "R12";
        enable_with(0, 1, 0, 0);
        check("R4", "cnt three", int'(cnt), 3);
        tag = "R6";
        g3 = 1; g4 = 1;
        repeat (8) cyc();
        check("R6", "cnt held", int'(cnt), 3);
        check("R8", "phase4 off", int'(pwm[3]), 0);
        g3 = 0; g4 = 0;

        tag = "R11";
        en = 0;
        cyc();
        tag = "R5";
        enable_with(0, 0, 1, 0);
        check("R5", "cnt two", int'(cnt), 2);
        tag = "R8";
        for (int c = 0; c < 12; c++) begin
            rq = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            cyc();
        end
        check("R8", "upper off", int'(pwm[3:2]), 0);
        rq = '0;

        en = 0;
        cyc();
        tag = "R5";
        enable_with(1, 1, 1, 1);
        check("R5", "cnt two both", int'(cnt), 2);

        // random traffic with occasional disables
        tag = "R7";
        for (int c = 0; c < 400; c++) begin
            en = ($urandom_range(0, 39) != 0);
            g3 = ($urandom_range(0, 5) == 0);
            g4 = ($urandom_range(0, 3) == 0);
            rq = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            cyc();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule